// File: doc/BRIEF.md
# Display Bus Request Sequencer

This block sits on the display side of a tile-based video path and decides when to steal the system bus for tile fetches. It counts scanlines within a tile row and tile slots within a scanline. One scanline before a new tile row is first shown, it raises a bus request. On the next line, the fetch line, it issues one fetch strobe per tile-slot pulse for which the grant is held. It drops the request as soon as the last tile of the row has been strobed.

On every other line of the row it keeps strobing once per tile slot with no request. The tile buffer downstream then replays the row it already holds. The sequencer never waits for the grant. A fetch line that passes without a grant is not retried, so the old row is shown again.

Timing comes from three inputs: a frame-start pulse, a line-start pulse and a tile-slot pulse. An active-display flag gates the whole block. Both outputs are registered and change one clock after the input that causes them.

Top module: `disp_busreq_seq`

## Requirements
- R1: While rst_ni is low and after its release, bus_req_o and fetch_o are 0. The line index starts at the preparation line (index LINES_PER_ROW-1) with the tile count at 0. No request is raised until a line-start or frame-start pulse arrives with active_i high.
- R2: A line_start_i pulse with active_i high that moves the line index to LINES_PER_ROW-1 (the preparation line) sets bus_req_o to 1 one cycle later.
- R3: On the fetch line (index 0), fetch_o is 1 one cycle after a slot_i pulse only if grant_i and bus_req_o were both 1 at that edge.
- R4: On the fetch line, bus_req_o goes to 0 in the same cycle in which fetch_o shows the TILES_PER_ROW-th strobe of that line.
- R5: If the fetch line ends before all tiles were strobed, bus_req_o goes to 0 one cycle after the next line_start_i. It is raised again only at the next preparation line.
- R6: On every line other than the fetch line, fetch_o is 1 one cycle after each slot_i pulse, whatever grant_i is.
- R7: At most TILES_PER_ROW strobes are issued per line. Further slot_i pulses in that line produce no strobe.
- R8: With active_i low, fetch_o and bus_req_o are 0 one cycle later, and the line index and tile count hold.
- R9: frame_start_i takes priority over line_start_i. It moves the sequencer to the preparation line with the tile count at 0, and sets bus_req_o to the value of active_i one cycle later.
- R10: An active line_start_i advances the line index modulo LINES_PER_ROW and clears the tile count. A slot_i pulse in the same cycle as a line_start_i or frame_start_i gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Start-of-frame pulse |
| line_start_i | input | 1 | Start-of-scanline pulse |
| slot_i | input | 1 | Tile-slot timing pulse |
| active_i | input | 1 | Active display flag |
| grant_i | input | 1 | Bus grant from the processor |
| bus_req_o | output | 1 | Bus request |
| fetch_o | output | 1 | Tile fetch strobe |

## Verification
The bench builds the block with TILES_PER_ROW=5 and LINES_PER_ROW=4. With a line of about a dozen cycles, slot pulses routinely run past the tile limit, so saturation is exercised. Row wrap, the preparation line, fetch lines that only partly complete, and lines whose grant is withheld all recur many times within a few thousand cycles. Random frame starts and inactive stretches land inside fetch lines and preparation lines, and collide with line starts.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;
  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_REPLAY = 2'd1,
    PH_PREP   = 2'd2
  } line_phase_e;
endpackage

// File: rtl/disp_line_ctr.sv
module disp_line_ctr
  import disp_seq_pkg::*;
#(
  parameter int unsigned LINES = 16,
  localparam int unsigned LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_start_i,
  input  logic        line_start_i,
  input  logic        active_i,
  output line_phase_e phase_o,
  output line_phase_e phase_next_o
);
  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  logic [LW-1:0] line_q, line_nx;

  assign line_nx = (line_q == LAST) ? '0 : line_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       line_q <= LAST;
    else if (frame_start_i)            line_q <= LAST;
    else if (line_start_i && active_i) line_q <= line_nx;
  end

  function automatic line_phase_e phase_of(logic [LW-1:0] idx);
    if (idx == '0)        return PH_FETCH;
    else if (idx == LAST) return PH_PREP;
    else                  return PH_REPLAY;
  endfunction

  assign phase_o      = phase_of(line_q);
  assign phase_next_o = phase_of(line_nx);
endmodule

// File: rtl/disp_tile_ctr.sv
module disp_tile_ctr #(
  parameter int unsigned TILES = 20,
  localparam int unsigned TW   = $clog2(TILES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic full_o,
  output logic last_o
);
  logic [TW-1:0] tile_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tile_q <= '0;
    else if (clr_i)             tile_q <= '0;
    else if (inc_i && !full_o)  tile_q <= tile_q + 1'b1;
  end

  assign full_o = (tile_q == TW'(TILES));
  assign last_o = (tile_q == TW'(TILES - 1));
endmodule

// File: rtl/disp_busreq_seq.sv
module disp_busreq_seq
  import disp_seq_pkg::*;
#(
  parameter int unsigned TILES_PER_ROW = 20,
  parameter int unsigned LINES_PER_ROW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic line_start_i,
  input  logic slot_i,
  input  logic active_i,
  input  logic grant_i,
  output logic bus_req_o,
  output logic fetch_o
);
  line_phase_e phase, phase_next;
  logic        tile_full, tile_last, strobe, req_q, fetch_q, tile_clr;

  disp_line_ctr #(.LINES(LINES_PER_ROW)) u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .line_start_i (line_start_i),
    .active_i     (active_i),
    .phase_o      (phase),
    .phase_next_o (phase_next)
  );

  assign tile_clr = frame_start_i || (line_start_i && active_i);

  disp_tile_ctr #(.TILES(TILES_PER_ROW)) u_tile (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tile_clr),
    .inc_i (strobe),
    .full_o(tile_full),
    .last_o(tile_last)
  );

  // fetch line strobes only under a held grant; other lines replay freely
  assign strobe = active_i && slot_i && !frame_start_i && !line_start_i &&
                  !tile_full && ((phase != PH_FETCH) || (req_q && grant_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else if (frame_start_i) begin
      req_q <= active_i;
    end else if (line_start_i) begin
      req_q <= active_i && ((phase_next == PH_PREP) ||
                            ((phase_next == PH_FETCH) && req_q));
    end else if (!active_i) begin
      req_q <= 1'b0;
    end else if (strobe && (phase == PH_FETCH) && tile_last) begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fetch_q <= 1'b0;
    else         fetch_q <= strobe;
  end

  assign bus_req_o = req_q;
  assign fetch_o   = fetch_q;
endmodule

// File: rtl/disp_busreq_seq_chk.sv
module disp_busreq_seq_chk
  import disp_seq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        frame_start_i,
  input logic        line_start_i,
  input logic        slot_i,
  input logic        active_i,
  input logic        grant_i,
  input logic        bus_req_o,
  input logic        fetch_o,
  input line_phase_e phase
);
  assert_strobe_from_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> $past(slot_i) && $past(active_i));

  assert_fetch_needs_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o && phase == PH_FETCH) |-> $past(grant_i) && $past(bus_req_o));

  assert_inactive_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(active_i) |-> !fetch_o && !bus_req_o);

  assert_req_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(frame_start_i) || $past(line_start_i));

  assert_no_strobe_at_line_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> !$past(line_start_i) && !$past(frame_start_i));

  assert_frame_start_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (bus_req_o == $past(active_i)));
endmodule

bind disp_busreq_seq disp_busreq_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .line_start_i (line_start_i),
  .slot_i       (slot_i),
  .active_i     (active_i),
  .grant_i      (grant_i),
  .bus_req_o    (bus_req_o),
  .fetch_o      (fetch_o),
  .phase        (phase)
);

// File: tb/tb_disp_busreq_seq.sv
module tb_disp_busreq_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T = 5;
  localparam int L = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fs = 0, ls = 0, sl = 0, act = 0, gr = 0;
  logic bus_req, fetch;
  int   checks = 0, failures = 0;

  // reference state
  int ml = L - 1, mt = 0;
  bit mr = 0, mf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_busreq_seq #(.TILES_PER_ROW(T), .LINES_PER_ROW(L)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .line_start_i(ls),
    .slot_i(sl), .active_i(act), .grant_i(gr), .bus_req_o(bus_req), .fetch_o(fetch)
  );

  task automatic check(string tag, logic a, logic e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, a, e, $time);
    end
  endtask

  task automatic model_edge(bit f, bit l, bit s, bit a, bit g);
    bit prev_r = mr;
    mf = 0;
    if (f) begin
      ml = L - 1; mt = 0; mr = a;
    end else if (l) begin
      if (a) begin
        ml = (ml + 1) % L; mt = 0;
        mr = (ml == L - 1) || (ml == 0 && prev_r);
      end else mr = 0;
    end else if (!a) begin
      mr = 0;
    end else if (s && mt < T && (ml != 0 || (prev_r && g))) begin
      mf = 1; mt++;
      if (ml == 0 && mt == T) mr = 0;
    end
  endtask

  task automatic step(bit f, bit l, bit s, bit a, bit g);
    string rt, ft;
    int    line_before;
    @(negedge clk);
    fs = f; ls = l; sl = s; act = a; gr = g;
    line_before = ml;
    @(posedge clk);
    model_edge(f, l, s, a, g);
    #(CLK_PERIOD/4);
    rt = f ? "R9" : l ? "R5" : !a ? "R8" : "R4";
    ft = !a ? "R8" : (line_before == 0) ? "R3" : "R6";
    check({rt, " req"}, bus_req, mr);
    check({ft, " fetch"}, fetch, mf);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset req", bus_req, 1'b0);
    check("R1 reset fetch", fetch, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(0,0,0,1,0); check("R1 no req before line start", bus_req, 1'b0);
    step(1,1,0,1,0); check("R9 frame start req", bus_req, 1'b1);
    for (int i = 0; i < T; i++) begin
      step(0,0,1,1,0); check("R6 prep line replay", fetch, 1'b1);
    end
    step(0,0,1,1,0); check("R7 saturation", fetch, 1'b0);
    step(0,1,0,1,0); check("R10 enter fetch line, req held", bus_req, 1'b1);
    step(0,0,1,1,0); check("R3 no grant no strobe", fetch, 1'b0);
    for (int i = 0; i < T; i++) begin
      step(0,0,1,1,1);
      check("R3 granted strobe", fetch, 1'b1);
      check("R4 release point", bus_req, (i == T - 1) ? 1'b0 : 1'b1);
    end
    step(0,1,1,1,1); check("R10 slot at line start", fetch, 1'b0);
    step(0,0,1,1,0); check("R6 replay without grant", fetch, 1'b1);
    step(0,1,0,1,0); check("R2 not yet", bus_req, 1'b0);
    step(0,1,0,1,0); check("R2 prep line req", bus_req, 1'b1);
    step(0,1,0,1,0); check("R10 wrap to fetch line", bus_req, 1'b1);
    step(0,0,1,1,1); step(0,0,1,1,1);
    check("R5 partial fetch req held", bus_req, 1'b1);
    step(0,1,0,1,1); check("R5 no retry", bus_req, 1'b0);
    step(0,0,1,1,1); step(0,1,0,1,0); step(0,1,0,1,0);
    check("R2 next prep line", bus_req, 1'b1);
    step(0,0,1,0,1); check("R8 inactive req", bus_req, 1'b0);
    check("R8 inactive fetch", fetch, 1'b0);
    step(0,1,0,0,0); step(0,0,1,1,0);
    check("R8 counters held", fetch, 1'b1);

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      bit f = ($urandom % 200) == 0;
      bit l = ($urandom % 12) == 0;
      bit s = ($urandom % 2) == 0;
      bit a = ($urandom % 16) != 0;
      bit g = ($urandom % 4) != 0;
      step(f, l, s, a, g);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule